// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a system timer that lives on a peripheral register bus and counts time from a separate slow clock, nominally 32.768 kHz. A free-running real-time counter advances once per programmable number of slow-clock cycles. An absolute-time alarm compares every new counter value against a programmed target. An independent periodic interval timer fires every N slow-clock cycles. Each of these raises a bit in a clear-on-read status register. A mask, built through a set-only register and a clear-only register, selects which status bits drive a single level interrupt.

The counter, the divider and both comparators run in the slow-clock domain. Configuration written on the bus moves into that domain through a toggle handshake. Events return as toggles that the bus domain turns into single-cycle pulses. The counter value crosses as a Gray code, so a bus read always sees a value that the counter actually held. Writes to the same configuration register must be spaced by at least three slow-clock cycles.

Top module: `slow_sys_timer`

## Requirements
- R1: The real-time counter is CNT_W bits wide (20 by default). It increments by exactly one per prescaler period and wraps from all ones to zero without stopping.
- R2: The prescaler register (offset 1) gives the number of slow-clock cycles per counter increment. A value of 1 advances the counter every slow cycle, 0 means 2^PRE_W cycles, and the reset value PRE_RST (32768 by default) gives one increment per second. Writing the prescaler restarts the divider.
- R3: The alarm status bit (status bit 3) is set when the counter steps to a value equal to the alarm register (offset 6). Nothing happens while the counter merely holds that value.
- R4: If the alarm is written with the value the counter holds at the time, no alarm occurs until the counter has wrapped all the way around.
- R5: The periodic interval status bit (status bit 0) is set once every N slow-clock cycles, where N is the interval register (offset 0). N = 0 means 2^PIT_W. Writing the interval restarts its count.
- R6: Status (offset 2) holds bit0 periodic, bit1 watchdog, bit2 counter increment and bit3 alarm. The watchdog bit always reads 0. A read returns the bits and clears them all. An event that arrives in the same cycle as the clearing read survives it.
- R7: Writing a 1 to a bit at offset 3 sets that mask bit, and writing a 1 at offset 4 clears it. Zero bits leave the mask unchanged. The mask reads back at offset 5 with the same bit order, and offsets 3 and 4 read as 0.
- R8: The irq output goes high one bus cycle after any status bit is set together with its mask bit. It is low one cycle after no such pair remains.
- R9: A read of the counter (offset 7) never returns a torn value. Successive reads differ by 0 or +1 modulo 2^CNT_W whenever they are closer together than one increment.
- R10: After reset, interval reads 0, prescaler reads PRE_RST, alarm, mask and status read 0, the counter reads 0 and irq is low. Interval, prescaler and alarm read back the values last written.
- R11: Each periodic, increment or alarm event sets its status bit exactly once. With the status read continuously, the number of reads that see a bit equals the number of events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| sclk | input | 1 | Slow clock that drives the counter |
| srst_n | input | 1 | Slow-domain synchronous reset, active low |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe, one bus cycle per access |
| bus_rd | input | 1 | Read strobe, one bus cycle per access; clears status at offset 2 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Level interrupt: any masked-in status bit set |

## Verification
The bench builds the timer with a 6-bit counter, a 5-bit prescaler reset to 16 and a 4-bit interval. A full counter wrap therefore takes only 64 increments, and the wrap-delayed alarm of R4 and the wrap of R1 fall within a short run. Small registers also make it cheap to sweep several prescaler and interval values, including 0, which stands for the full power of two. Expected event counts and counter deltas come from slow-clock edge arithmetic in the bench. Each comparison allows one count of slack for the synchronizer latency.

// File: rtl/slow_timer_pkg.sv
// Package: shared register offsets and status bit positions for the
// slow-clock system timer. Assumes a word-addressed bus of eight registers.
package slow_timer_pkg;

    localparam int ADDR_W = 3;
    localparam int STAT_W = 4;
    localparam int EVT_W  = 3;   // slow-domain events: periodic, increment, alarm

    typedef enum logic [ADDR_W-1:0] {
        OFS_INTERVAL = 3'd0,
        OFS_PRESCALE = 3'd1,
        OFS_STATUS   = 3'd2,
        OFS_MASK_SET = 3'd3,
        OFS_MASK_CLR = 3'd4,
        OFS_MASK     = 3'd5,
        OFS_ALARM    = 3'd6,
        OFS_COUNT    = 3'd7
    } reg_ofs_e;

    // status / mask bit positions
    localparam int SB_PERIODIC = 0;
    localparam int SB_WATCHDOG = 1;
    localparam int SB_INCR     = 2;
    localparam int SB_ALARM    = 3;

    // slow-domain event toggle positions
    localparam int EV_PERIODIC = 0;
    localparam int EV_INCR     = 1;
    localparam int EV_ALARM    = 2;

endpackage

// File: rtl/st_cfg_xfer.sv
// Module: st_cfg_xfer
// Holds one configuration value in the bus domain and hands it to the slow
// domain with a toggle handshake. Assumes the bus copy stays unchanged for at
// least three slow-clock cycles after a load, so the slow side samples a
// stable word when it sees the synchronized toggle edge.
module st_cfg_xfer #(
    parameter int             W   = 16,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         srst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] bus_val,
    output logic [W-1:0] slow_val,
    output logic         slow_load
);

    logic       tog_q;
    logic [2:0] tsync_q;

    // bus side: capture the new word and flip the request toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_val <= RST;
            tog_q   <= 1'b0;
        end else if (load) begin
            bus_val <= din;
            tog_q   <= ~tog_q;
        end
    end

    // slow side: two-flop synchronizer plus one delay stage for edge detection
    always_ff @(posedge sclk) begin
        if (!srst_n) tsync_q <= '0;
        else         tsync_q <= {tsync_q[1:0], tog_q};
    end

    assign slow_load = tsync_q[2] ^ tsync_q[1];

    // slow side: take the stable bus word when the request edge arrives
    always_ff @(posedge sclk) begin
        if (!srst_n)        slow_val <= RST;
        else if (slow_load) slow_val <= bus_val;
    end

endmodule

// File: rtl/st_evt_sync.sv
// Module: st_evt_sync
// Turns each slow-domain event toggle into a one-cycle pulse in the bus
// domain. Assumes toggles of one bit are at least three bus cycles apart.
module st_evt_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tgl_in,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [2:0] sync_q;

        // per-event two-flop synchronizer plus delay stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[1:0], tgl_in[i]};
        end

        assign pulse[i] = sync_q[2] ^ sync_q[1];
    end

endmodule

// File: rtl/st_count_sync.sv
// Module: st_count_sync
// Brings the Gray-coded counter into the bus domain through two flops and
// converts it back to binary. Assumes the source changes by at most one
// Gray bit per slow cycle and the slow clock is slower than the bus clock.
module st_count_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] g1_q, g2_q;

    // two-flop synchronizer on the Gray word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q <= '0;
            g2_q <= '0;
        end else begin
            g1_q <= gray_in;
            g2_q <= g1_q;
        end
    end

    // each binary bit is the parity of all Gray bits at or above it
    for (genvar i = 0; i < W; i++) begin : g_conv
        assign bin_out[i] = ^g2_q[W-1:i];
    end

endmodule

// File: rtl/st_slow_core.sv
// Module: st_slow_core
// Slow-domain engine: prescaler divider, wrapping real-time counter kept
// as a Gray copy, absolute alarm compare on each counter step, and the
// periodic interval counter. Each event flips a toggle for the bus side.
// Assumes load pulses come from st_cfg_xfer in this same domain.
module st_slow_core
    import slow_timer_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16,
    parameter int PIT_W = 16
) (
    input  logic             sclk,
    input  logic             srst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             prescale_ld,
    input  logic [PIT_W-1:0] interval,
    input  logic             interval_ld,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] cnt_gray,
    output logic [EVT_W-1:0] evt_tgl
);

    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
    localparam logic [PIT_W-1:0] PIT_ONE = PIT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] div_last;
    logic [PIT_W-1:0] pit_q;
    logic [PIT_W-1:0] pit_last;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic             pit_hit;
    logic             alm_hit;

    // a value of 0 wraps to all ones, giving 2^W cycles
    assign div_last = prescale - PRE_ONE;
    assign pit_last = interval - PIT_ONE;
    assign step     = !prescale_ld && (div_q == div_last);
    assign pit_hit  = !interval_ld && (pit_q == pit_last);
    assign cnt_nxt  = cnt_q + CNT_ONE;
    assign alm_hit  = step && (cnt_nxt == alarm);

    // prescaler divider, restarted on a new prescaler value
    always_ff @(posedge sclk) begin
        if (!srst_n)                  div_q <= '0;
        else if (prescale_ld || step) div_q <= '0;
        else                          div_q <= div_q + PRE_ONE;
    end

    // real-time counter and its Gray copy, advanced together
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            cnt_q    <= '0;
            cnt_gray <= '0;
        end else if (step) begin
            cnt_q    <= cnt_nxt;
            cnt_gray <= cnt_nxt ^ (cnt_nxt >> 1);
        end
    end

    // periodic interval counter, restarted on a new interval value
    always_ff @(posedge sclk) begin
        if (!srst_n)                     pit_q <= '0;
        else if (interval_ld || pit_hit) pit_q <= '0;
        else                             pit_q <= pit_q + PIT_ONE;
    end

    // event toggles handed to the bus domain
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            evt_tgl <= '0;
        end else begin
            if (pit_hit) evt_tgl[EV_PERIODIC] <= ~evt_tgl[EV_PERIODIC];
            if (step)    evt_tgl[EV_INCR]     <= ~evt_tgl[EV_INCR];
            if (alm_hit) evt_tgl[EV_ALARM]    <= ~evt_tgl[EV_ALARM];
        end
    end

endmodule

// File: rtl/slow_sys_timer.sv
// Module: slow_sys_timer (top)
// Register bus front end of the slow-clock system timer: configuration
// registers, clear-on-read status, set/clear interrupt mask and level irq.
// Assumes one-cycle read/write strobes and a slow clock at most a third of
// the bus clock rate. Both resets are asserted together.
module slow_sys_timer
    import slow_timer_pkg::*;
#(
    parameter int               CNT_W   = 20,
    parameter int               PRE_W   = 16,
    parameter int               PIT_W   = 16,
    parameter int               DATA_W  = 32,
    parameter logic [PRE_W-1:0] PRE_RST = PRE_W'(32768),
    parameter logic [PIT_W-1:0] PIT_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              srst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_ofs_e          ofs;
    logic              wdata_unused;
    logic              ld_ivl, ld_pre, ld_alm;
    logic [PIT_W-1:0]  ivl_bus, ivl_slow;
    logic [PRE_W-1:0]  pre_bus, pre_slow;
    logic [CNT_W-1:0]  alm_bus, alm_slow;
    logic              ivl_sld, pre_sld, alm_sld;
    logic [CNT_W-1:0]  slow_gray;
    logic [CNT_W-1:0]  cnt_bus;
    logic [EVT_W-1:0]  slow_tgl;
    logic [EVT_W-1:0]  evt_pulse;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;
    logic              stat_clr;

    assign ofs          = reg_ofs_e'(bus_addr);
    assign wdata_unused = ^bus_wdata;
    assign ld_ivl       = bus_wr && (ofs == OFS_INTERVAL);
    assign ld_pre       = bus_wr && (ofs == OFS_PRESCALE);
    assign ld_alm       = bus_wr && (ofs == OFS_ALARM);
    assign stat_clr     = bus_rd && (ofs == OFS_STATUS);

    st_cfg_xfer #(.W(PIT_W), .RST(PIT_RST)) u_ivl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .load(ld_ivl), .din(bus_wdata[PIT_W-1:0]),
        .bus_val(ivl_bus), .slow_val(ivl_slow), .slow_load(ivl_sld)
    );

    st_cfg_xfer #(.W(PRE_W), .RST(PRE_RST)) u_pre (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .load(ld_pre), .din(bus_wdata[PRE_W-1:0]),
        .bus_val(pre_bus), .slow_val(pre_slow), .slow_load(pre_sld)
    );

    st_cfg_xfer #(.W(CNT_W), .RST('0)) u_alm (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .load(ld_alm), .din(bus_wdata[CNT_W-1:0]),
        .bus_val(alm_bus), .slow_val(alm_slow), .slow_load(alm_sld)
    );

    // the alarm load pulse needs no action in the core: the compare reads the new value
    logic alm_sld_unused;
    assign alm_sld_unused = alm_sld;

    st_slow_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W)) u_core (
        .sclk(sclk), .srst_n(srst_n),
        .prescale(pre_slow), .prescale_ld(pre_sld),
        .interval(ivl_slow), .interval_ld(ivl_sld),
        .alarm(alm_slow),
        .cnt_gray(slow_gray), .evt_tgl(slow_tgl)
    );

    st_count_sync #(.W(CNT_W)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .gray_in(slow_gray), .bin_out(cnt_bus)
    );

    st_evt_sync #(.N(EVT_W)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .tgl_in(slow_tgl), .pulse(evt_pulse)
    );

    // route event pulses to their status positions; watchdog stays 0
    always_comb begin
        set_v              = '0;
        set_v[SB_PERIODIC] = evt_pulse[EV_PERIODIC];
        set_v[SB_INCR]     = evt_pulse[EV_INCR];
        set_v[SB_ALARM]    = evt_pulse[EV_ALARM];
        set_v[SB_WATCHDOG] = 1'b0;
    end

    // status: clear on read, new events win over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_clr ? '0 : stat_q) | set_v;
    end

    // interrupt mask: set-only and clear-only write ports
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (bus_wr && (ofs == OFS_MASK_SET))
            mask_q <= mask_q | bus_wdata[STAT_W-1:0];
        else if (bus_wr && (ofs == OFS_MASK_CLR))
            mask_q <= mask_q & ~bus_wdata[STAT_W-1:0];
    end

    // registered level interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat_q & mask_q);
    end

    // read data multiplexer, zero-extended to the bus width
    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_INTERVAL: bus_rdata[PIT_W-1:0]  = ivl_bus;
            OFS_PRESCALE: bus_rdata[PRE_W-1:0]  = pre_bus;
            OFS_STATUS:   bus_rdata[STAT_W-1:0] = stat_q;
            OFS_MASK_SET: bus_rdata             = '0;
            OFS_MASK_CLR: bus_rdata             = '0;
            OFS_MASK:     bus_rdata[STAT_W-1:0] = mask_q;
            OFS_ALARM:    bus_rdata[CNT_W-1:0]  = alm_bus;
            OFS_COUNT:    bus_rdata[CNT_W-1:0]  = cnt_bus;
            default:      bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/slow_sys_timer_chk.sv
// Module: slow_sys_timer_chk
// Property checker bound to slow_sys_timer. Observes the status, mask,
// irq and counter crossing; drives nothing.
module slow_sys_timer_chk #(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              srst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [3:0]        stat_q,
    input logic [3:0]        set_v,
    input logic [3:0]        mask_q,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_bus,
    input logic [CNT_W-1:0]  slow_gray
);

    // R6
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2) |=> (stat_q == $past(set_v)));

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == 3'd2) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=>
            (mask_q == ($past(mask_q) | $past(bus_wdata[3:0]))));

    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=>
            (mask_q == ($past(mask_q) & ~$past(bus_wdata[3:0]))));

    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 3'd3 || bus_addr == 3'd4)) |=> $stable(mask_q));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q)) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & mask_q)) |=> !irq);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bus != $past(cnt_bus)) |-> (cnt_bus == $past(cnt_bus) + CNT_W'(1)));

    // R9
    gray_one_bit_chk: assert property (@(posedge sclk) disable iff (!srst_n)
        ($countones(slow_gray ^ $past(slow_gray)) <= 1));

endmodule

bind slow_sys_timer slow_sys_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .stat_q(stat_q), .set_v(set_v), .mask_q(mask_q), .irq(irq),
    .cnt_bus(cnt_bus), .slow_gray(slow_gray)
);

// File: tb/slow_sys_timer_tb.sv
// Bench: small configuration (6-bit counter) with arithmetic expectations.
module slow_sys_timer_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_PERIOD = 70;
    localparam int CNT_W  = 6;
    localparam int PRE_W  = 5;
    localparam int PIT_W  = 4;
    localparam int DATA_W = 32;
    localparam int CMASK  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              sclk = 1'b0;
    logic              rst_n = 1'b0;
    logic              srst_n = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    int sticks = 0;
    int wd_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(SCLK_PERIOD/2) sclk = ~sclk;
    always @(posedge sclk) sticks++;

    slow_sys_timer #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W), .DATA_W(DATA_W),
        .PRE_RST(5'd16), .PIT_RST(4'd0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1 d = int'(bus_rdata);
        if (a == 2 && d[1]) wd_seen++;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_s(input int n);
        repeat (n) @(posedge sclk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog: a hung run is a failure and still prints the summary
    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, p, prev, nw, bad, wraps, c0, c1, t0, hits, incs, per, alm, dlt;
        repeat (3) @(posedge sclk);
        @(negedge clk);
        srst_n = 1'b1; rst_n = 1'b1;

        // R10 reset values
        rd_reg(0, v); check(v == 0,  "R10", "interval reset", v, 0);
        rd_reg(1, v); check(v == 16, "R10", "prescaler reset", v, 16);
        rd_reg(6, v); check(v == 0,  "R10", "alarm reset", v, 0);
        rd_reg(5, v); check(v == 0,  "R10", "mask reset", v, 0);
        rd_reg(2, v); check(v == 0,  "R10", "status reset", v, 0);
        rd_reg(7, v); check(v == 0,  "R10", "counter reset", v, 0);
        check(irq == 1'b0, "R10", "irq reset", int'(irq), 0);

        // R7 mask set/clear, zero bits ignored, strobe offsets read 0
        wr_reg(3, 9);  rd_reg(5, v); check(v == 9,  "R7", "mask set 1001", v, 9);
        wr_reg(3, 2);  rd_reg(5, v); check(v == 11, "R7", "mask set 0010", v, 11);
        wr_reg(4, 1);  rd_reg(5, v); check(v == 10, "R7", "mask clr 0001", v, 10);
        wr_reg(4, 0);  rd_reg(5, v); check(v == 10, "R7", "mask clr 0000", v, 10);
        wr_reg(3, 0);  rd_reg(5, v); check(v == 10, "R7", "mask set 0000", v, 10);
        rd_reg(3, v); check(v == 0, "R7", "set port reads 0", v, 0);
        rd_reg(4, v); check(v == 0, "R7", "clr port reads 0", v, 0);
        wr_reg(4, 15);

        // R2 prescaler sweep: 8 increments per 8*P slow cycles
        foreach (p_list[i]) begin
            p = p_list[i];
            wr_reg(1, p); wait_s(6);
            rd_reg(1, v); check(v == p, "R10", "prescaler readback", v, p);
            per = (p == 0) ? 32 : p;
            rd_reg(7, c0); t0 = sticks;
            while (sticks < t0 + 8 * per) @(negedge clk);
            rd_reg(7, c1);
            dlt = (c1 - c0) & CMASK;
            check(dlt >= 7 && dlt <= 9, "R2", $sformatf("delta for prescaler %0d", p), dlt, 8);
        end

        // R9 / R1: continuous counter reads with prescaler 1, across wraps
        wr_reg(1, 1); wait_s(6);
        rd_reg(7, prev); bad = 0; wraps = 0;
        for (int k = 0; k < 5000; k++) begin
            rd_reg(7, nw);
            if (((nw - prev) & CMASK) > 1) bad++;
            if (nw < prev) wraps++;
            prev = nw;
        end
        check(bad == 0, "R9", "non-sequential counter reads", bad, 0);
        check(wraps >= 1, "R1", "counter wrapped to zero", wraps, 1);

        // R5 / R11 / R1: event counts over a window, prescaler 1
        foreach (n_list[i]) begin
            per = (n_list[i] == 0) ? 16 : n_list[i];
            wr_reg(0, n_list[i]); wait_s(5);
            rd_reg(0, v); check(v == n_list[i], "R10", "interval readback", v, n_list[i]);
            rd_reg(2, v);
            t0 = sticks; hits = 0; incs = 0;
            while (sticks < t0 + 10 * per) begin
                rd_reg(2, v);
                if (v[0]) hits++;
                if (v[2]) incs++;
            end
            check(hits >= 9 && hits <= 11, "R5", $sformatf("periodic events N=%0d", n_list[i]), hits, 10);
            check(incs >= 10*per - 1 && incs <= 10*per + 1, "R11",
                  $sformatf("increment events N=%0d", n_list[i]), incs, 10*per);
        end

        // R3: alarm ahead of the counter fires when the counter reaches it
        rd_reg(7, c0);
        alm = (c0 + 20) & CMASK;
        wr_reg(6, alm); wait_s(5);
        rd_reg(6, v); check(v == alm, "R10", "alarm readback", v, alm);
        rd_reg(2, v);
        t0 = sticks; hits = 0; c1 = -1;
        while (sticks < t0 + 40 && hits == 0) begin
            rd_reg(2, v);
            if (v[3]) begin hits = 1; rd_reg(7, c1); end
        end
        check(hits == 1, "R3", "alarm seen", hits, 1);
        dlt = (c1 - alm) & CMASK;
        check(dlt <= 2, "R3", "counter at alarm", c1, alm);

        // R4: alarm equal to the current count waits a full wrap (prescaler 2)
        wr_reg(1, 2); wait_s(6);
        rd_reg(7, c0);
        wr_reg(6, c0); t0 = sticks; wait_s(6);
        rd_reg(2, v);
        hits = 0;
        while (sticks < t0 + 110) begin
            rd_reg(2, v);
            if (v[3]) hits++;
        end
        check(hits == 0, "R4", "no early alarm", hits, 0);
        while (sticks < t0 + 150 && hits == 0) begin
            rd_reg(2, v);
            if (v[3]) hits++;
        end
        check(hits == 1, "R4", "alarm after wrap", hits, 1);

        // R8: irq follows masked status
        wr_reg(4, 15); wr_reg(0, 3); wait_s(8);
        check(irq == 1'b0, "R8", "irq masked off", int'(irq), 0);
        wr_reg(3, 1); repeat (2) @(negedge clk);
        check(irq == 1'b1, "R8", "irq on periodic", int'(irq), 1);
        wr_reg(4, 1); repeat (2) @(negedge clk);
        check(irq == 1'b0, "R8", "irq after mask clear", int'(irq), 0);
        rd_reg(2, v);
        check(v[0] == 1'b1, "R6", "status kept while masked", v & 1, 1);

        // R6 watchdog bit never seen set in any status read
        check(wd_seen == 0, "R6", "watchdog bit reads", wd_seen, 0);

        finish_run();
    end

    int p_list[5] = '{1, 2, 3, 5, 0};
    int n_list[5] = '{2, 3, 5, 7, 0};

endmodule